// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block gathers thirteen level-sensitive interrupt lines from board peripherals, gates each one with a bit of a software-written enable register, and presents a 4-bit encoded interrupt level to a processor. Each source has a fixed priority number from 0 to 12, and 0 is the most urgent. The encoded output is the bitwise inverse of the winning priority number. When no enabled source is active the output is 0. The most urgent source gives 15.

The same block answers a small 64-byte register window on a simple synchronous bus. The bus has an address, a write strobe, write data and combinational read data. The window holds the enable register, a general-purpose output latch, a power-off trigger that emits a one-cycle shutdown pulse, and a constant identification word.

Top module: `board_int_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable register and output latch clear to 0, `lvl_o` becomes 0 and `shutdown_o` becomes 0.
- R2: Input `src_i[p]` is the source with priority number p. It is pending only while it is high and its enable bit is set. The enable bit for priorities 0..12 is, in order: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Enable bits 1, 2 and 3 gate nothing.
- R3: Among the pending sources, the one with the smallest priority number wins.
- R4: `lvl_o` equals the winning priority number XOR 4'hF. It is 4'h0 when nothing is pending.
- R5: `lvl_o` is registered. After each clock edge it reflects `src_i` and the enable register as they stood just before that edge. A write to the enable register at edge N therefore shows on `lvl_o` after edge N+1.
- R6: The enable register is at byte offset 0x00. It is 16 bits wide, and every bit can be written and read back.
- R7: The output latch is at offset 0x36. It is a 16-bit read/write store that changes only when written.
- R8: Offset 0x30 always reads 0. A write there with data bit 0 set drives `shutdown_o` high for the one cycle after that edge. A write there with bit 0 clear produces no pulse.
- R9: Offset 0x32 always reads 16'h0010, and writes to it change nothing.
- R10: Every other offset in the 6-bit window, including unaligned ones, reads 0. Writes to those offsets change no register and raise no pulse.
- R11: `reg_rdata` is combinational. It reflects the current `reg_addr` and register contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte offset into the register window |
| reg_we | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| src_i | input | 13 | Interrupt source levels, index = priority number |
| lvl_o | output | 4 | Encoded interrupt level, inverse of the winner |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
The level path is driven in several ways:
- Each source is raised alone with all enables set, which proves each entry of the priority-to-enable table in isolation.
- All sources are raised together while one enable bit at a time is cleared, which shows that only the winner's enable decides the output.
- A pair of sources is raised with the more urgent one's enable cleared, which separates a priority error from a gating error.
- A long pseudo-random mix of source levels and enable writes catches timing slips between the enable register and the level register.

Register traffic covers writes to the trigger with bit 0 set and clear, back-to-back triggers, writes to the identification word, and writes to unused and unaligned offsets. Together these separate decode errors from storage errors.

// File: rtl/bic_pkg.sv
// Package: shared constants for the board interrupt level aggregator.
// Assumes byte offsets inside a 64-byte window and a fixed source table.
package bic_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 6;
    localparam int LVL_W    = 4;
    localparam int NUM_SRC  = 13;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_PWROFF = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_LATCH  = 6'h36;

    localparam logic [DATA_W-1:0] IDENT_WORD = 16'h0010;

    // Enable bit that gates the source with priority number prio.
    function automatic int enable_bit_of(input int prio);
        case (prio)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/bic_src_map.sv
// Module: places each source level onto its enable-bit position in a
// 16-bit monitor word. Assumes sources are already synchronous to clk.
module bic_src_map
    import bic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = DATA_W
) (
    input  logic [N_SRC-1:0] src,
    output logic [W-1:0]     monitor
);
    logic [N_SRC-1:0][W-1:0] one_hot;

    // Each source drives a one-hot word at its enable position.
    for (genvar p = 0; p < N_SRC; p++) begin : g_place
        localparam int BIT = enable_bit_of(p);
        assign one_hot[p] = src[p] ? W'(1) << BIT : '0;
    end

    // Merge the per-source words into the monitor word.
    always_comb begin
        monitor = '0;
        for (int p = 0; p < N_SRC; p++) monitor |= one_hot[p];
    end
endmodule

// File: rtl/bic_prio_sel.sv
// Module: finds the lowest priority number whose monitor and enable bits
// are both set, and returns its 4-bit inverse (0 when none). Purely combinational.
module bic_prio_sel
    import bic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = DATA_W,
    parameter int LW    = LVL_W
) (
    input  logic [W-1:0]  monitor,
    input  logic [W-1:0]  enable,
    output logic [LW-1:0] level_n
);
    localparam logic [LW-1:0] IDLE = {LW{1'b1}};

    logic [W-1:0]     pending;
    logic [N_SRC-1:0] hit;
    logic [LW-1:0]    winner;
    logic             unused_pending;

    assign pending        = monitor & enable;
    assign unused_pending = ^pending;

    // Gather each priority's pending flag from its table position.
    for (genvar p = 0; p < N_SRC; p++) begin : g_hit
        localparam int BIT = enable_bit_of(p);
        assign hit[p] = pending[BIT];
    end

    // Scan from the least urgent upward so the smallest number wins.
    always_comb begin
        winner = IDLE;
        for (int p = N_SRC - 1; p >= 0; p--) begin
            if (hit[p]) winner = LW'(p);
        end
    end

    assign level_n = winner ^ IDLE;
endmodule

// File: rtl/bic_regs.sv
// Module: register window holding the enable word, output latch, power-off
// trigger and identification word. Assumes a single-cycle write strobe.
module bic_regs
    import bic_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic [W-1:0]  enable_q,
    output logic          shutdown_q
);
    logic [W-1:0] latch_q;
    logic sel_enable, sel_latch, sel_pwroff, sel_ident;

    assign sel_enable = (reg_addr == AW'(OFS_ENABLE));
    assign sel_latch  = (reg_addr == AW'(OFS_LATCH));
    assign sel_pwroff = (reg_addr == AW'(OFS_PWROFF));
    assign sel_ident  = (reg_addr == AW'(OFS_IDENT));

    // Stores the enable word and the output latch on their writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            latch_q  <= '0;
        end else if (reg_we) begin
            if (sel_enable) enable_q <= reg_wdata;
            if (sel_latch)  latch_q  <= reg_wdata;
        end
    end

    // Raises the shutdown pulse for one cycle per qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) shutdown_q <= 1'b0;
        else        shutdown_q <= reg_we && sel_pwroff && reg_wdata[0];
    end

    // Returns the addressed word; unknown offsets and the trigger read 0.
    always_comb begin
        reg_rdata = '0;
        if (sel_enable)     reg_rdata = enable_q;
        else if (sel_latch) reg_rdata = latch_q;
        else if (sel_ident) reg_rdata = W'(IDENT_WORD);
    end

    assert_ident_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ident |-> reg_rdata == W'(IDENT_WORD));
    assert_pwroff_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pwroff |-> reg_rdata == '0);
    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_q |-> $past(reg_we && sel_pwroff && reg_wdata[0]));
    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && sel_enable) |=> $stable(enable_q));
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && sel_latch) |=> $stable(latch_q));
endmodule

// File: rtl/board_int_ctrl.sv
// Module: top of the board interrupt level aggregator. Maps sources, gates
// them with the enable word, encodes the winner and registers the level.
// Assumes src_i is synchronous to clk.
module board_int_ctrl
    import bic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int LW    = LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_we,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic [N_SRC-1:0] src_i,
    output logic [LW-1:0]    lvl_o,
    output logic             shutdown_o
);
    logic [W-1:0]  monitor;
    logic [W-1:0]  enable_q;
    logic [LW-1:0] level_next;

    bic_regs #(.W(W), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .enable_q   (enable_q),
        .shutdown_q (shutdown_o)
    );

    bic_src_map #(.N_SRC(N_SRC), .W(W)) u_map (
        .src     (src_i),
        .monitor (monitor)
    );

    bic_prio_sel #(.N_SRC(N_SRC), .W(W), .LW(LW)) u_sel (
        .monitor (monitor),
        .enable  (enable_q),
        .level_n (level_next)
    );

    // Registers the encoded level once so it moves one clock after its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_o <= '0;
        else        lvl_o <= level_next;
    end

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |=> (lvl_o == '0));
    assert_top_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[0] && enable_q[enable_bit_of(0)]) |=> (lvl_o == {LW{1'b1}}));
    assert_no_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> (lvl_o == '0));
endmodule

// File: tb/test_board_int_ctrl.sv
module test_board_int_ctrl;
    localparam time CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [12:0] src_i = '0;
    logic [3:0]  lvl_o;
    logic        shutdown_o;

    int total = 0;
    int bad = 0;

    // Behavioural model state.
    int          m_bit [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    logic [15:0] m_enable = '0;
    logic [15:0] m_latch = '0;
    logic [3:0]  m_lvl = '0;
    logic        m_sd = 1'b0;
    int          pulses[$];

    always #(CLK_PER/2) clk = ~clk;

    board_int_ctrl i_board_int_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src_i),
        .lvl_o(lvl_o), .shutdown_o(shutdown_o)
    );

    function automatic logic [3:0] model_level(logic [12:0] s, logic [15:0] en);
        int best = 15;
        for (int p = 12; p >= 0; p--)
            if (s[p] && en[m_bit[p]]) best = p;
        return 4'(best) ^ 4'hF;
    endfunction

    function automatic logic [15:0] model_read(logic [5:0] a);
        case (a)
            6'h00:   return m_enable;
            6'h36:   return m_latch;
            6'h32:   return 16'h0010;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check read data, step model at posedge, compare.
    task automatic cyc(logic [5:0] a, logic w, logic [15:0] d, logic [12:0] s, string tag);
        reg_addr = a; reg_we = w; reg_wdata = d; src_i = s;
        #1;
        if (rst_n) check({tag, " R11 read"}, reg_rdata, model_read(a));
        @(posedge clk);
        if (!rst_n) begin
            m_enable = '0; m_latch = '0; m_lvl = '0; m_sd = 1'b0;
        end else begin
            m_lvl = model_level(s, m_enable);
            m_sd  = w && a == 6'h30 && d[0];
            if (m_sd) pulses.push_back(total);
            if (w && a == 6'h00) m_enable = d;
            if (w && a == 6'h36) m_latch = d;
        end
        @(negedge clk);
        check({tag, " R5 lvl"}, {12'b0, lvl_o}, {12'b0, m_lvl});
        check({tag, " R8 shutdown"}, {15'b0, shutdown_o}, {15'b0, m_sd});
    endtask

    initial begin
        #(CLK_PER * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        // R1: reset clears everything even with traffic and active sources.
        rst_n = 1'b0;
        cyc(6'h00, 1'b1, 16'hFFFF, 13'h1FFF, "R1 reset");
        cyc(6'h30, 1'b1, 16'h0001, 13'h1FFF, "R1 reset");
        rst_n = 1'b1;
        cyc(6'h00, 1'b0, 16'h0000, 13'h1FFF, "R1 after reset");
        check("R1 enable", reg_rdata, 16'h0000);

        // R6: enable register stores every bit.
        cyc(6'h00, 1'b1, 16'hA5A5, 13'h0, "R6 write");
        cyc(6'h00, 1'b0, 16'h0000, 13'h0, "R6 readback");
        cyc(6'h00, 1'b1, 16'hFFFF, 13'h0, "R6 all ones");

        // R2 R4: each source alone with all enables set.
        for (int p = 0; p < 13; p++) begin
            cyc(6'h00, 1'b0, 16'h0, 13'(1) << p, "R4 single");
            cyc(6'h00, 1'b0, 16'h0, 13'h0, "R4 idle");
        end

        // R2 R3: all high, clear one enable bit at a time.
        for (int b = 0; b < 16; b++) begin
            cyc(6'h00, 1'b1, ~(16'(1) << b), 13'h1FFF, "R2 enable walk");
            cyc(6'h00, 1'b0, 16'h0, 13'h1FFF, "R3 all high");
        end

        // R3: pair of sources, winner's enable cleared.
        cyc(6'h00, 1'b1, 16'hFFFF & ~16'h0800, 13'h0009, "R3 pair");
        cyc(6'h00, 1'b0, 16'h0, 13'h0009, "R3 pair masked");
        cyc(6'h00, 1'b1, 16'hFFFF, 13'h0009, "R3 pair restore");
        cyc(6'h00, 1'b0, 16'h0, 13'h0009, "R3 pair win");

        // R7: output latch.
        cyc(6'h36, 1'b1, 16'h1234, 13'h0, "R7 write");
        cyc(6'h36, 1'b0, 16'h0, 13'h0, "R7 read");
        cyc(6'h36, 1'b1, 16'hFEDC, 13'h0, "R7 rewrite");

        // R8: power-off trigger.
        cyc(6'h30, 1'b1, 16'hFFFE, 13'h0, "R8 bit0 clear");
        cyc(6'h30, 1'b1, 16'h0001, 13'h0, "R8 pulse");
        cyc(6'h30, 1'b1, 16'h0003, 13'h0, "R8 back to back");
        cyc(6'h30, 1'b0, 16'h0001, 13'h0, "R8 no strobe");

        // R9: identification word ignores writes.
        cyc(6'h32, 1'b1, 16'hFFFF, 13'h0, "R9 write");
        cyc(6'h32, 1'b0, 16'h0, 13'h0, "R9 read");

        // R10: other offsets, unaligned ones included.
        cyc(6'h02, 1'b1, 16'h0000, 13'h0, "R10 off02");
        cyc(6'h01, 1'b1, 16'h0000, 13'h0, "R10 off01");
        cyc(6'h31, 1'b1, 16'h0001, 13'h0, "R10 off31");
        cyc(6'h37, 1'b1, 16'h0000, 13'h0, "R10 off37");
        cyc(6'h3E, 1'b1, 16'h5555, 13'h0, "R10 off3E");
        cyc(6'h00, 1'b0, 16'h0, 13'h0, "R10 enable kept");
        cyc(6'h36, 1'b0, 16'h0, 13'h0, "R10 latch kept");

        // R5: pseudo-random mix of sources and register traffic.
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = 6'h00;
                3'd2:       a = 6'h30;
                3'd3:       a = 6'h36;
                3'd4:       a = 6'h32;
                default:    a = lfsr[8:3];
            endcase
            cyc(a, lfsr[9], {lfsr[7:0], lfsr[15:8]}, lfsr[12:0] & {13{lfsr[15]}} | 13'(lfsr[3:0]),
                "R5 mix");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule